// File: doc/BRIEF.md
# Access Legality Checker

This block watches the accesses a processor places on its local bus and decides, one access at a time, whether each is legal under rules that software programs through a small register write port. A memory access is illegal when its address falls inside one of two programmable holes, each described by an inclusive low and high address and switched on by its own enable bit. A programmed-I/O access is illegal when its command number is at or above the limit software set for its direction, or when it targets the reserved spare I/O group while software has not declared that group usable.

The first illegal access raises a sticky fault and stores the 16 low bits of its address. Later violations leave that stored address untouched until software clears the fault, which re-arms the capture. The block has no read path; the fault line and the stored address are its only outputs.

Top module: `acc_guard`

## Requirements
- R1: After reset, fault is 0 and fail_addr is 0x0000; every hole and the I/O limit check are off, and the spare I/O group is illegal.
- R2: A valid memory access (acc_is_io = 0) whose address satisfies low <= addr <= high of an enabled hole sets fault; addresses one below the low bound or one above the high bound do not.
- R3: A hole whose enable bit is 0, or whose low bound is greater than its high bound, never flags an access.
- R4: With the I/O check enabled (control bit 0), a valid I/O access flags when its command number, the 10 least significant address bits, is greater than or equal to the limit for its direction: output limit (select 1) for acc_is_out = 1, input limit (select 2) for acc_is_out = 0. A limit is taken from bits 9:0 of the written data; bits 15:10 are ignored.
- R5: With the I/O check disabled, a command number above either limit does not flag.
- R6: An I/O access whose address bits 15:10 lie in 0x30..0x3F (addresses 0xC000-0xFFFF) flags while control bit 1 is 0 and is legal while it is 1; memory accesses to the same addresses are not affected by this rule.
- R7: fail_addr captures the full address of a violating access only while no fault is pending; further violations leave it unchanged.
- R8: Writing the control register (select 0) with bit 2 set clears fault at that edge; if a violation arrives in the same cycle, fault stays 1 and fail_addr takes the new address.
- R9: An access with acc_valid = 0 never sets fault or changes fail_addr.
- R10: A register write takes effect for accesses from the next cycle on; an access in the same cycle as the write is judged by the old settings.
- R11: Control layout: bit 0 I/O check enable, bit 1 spare group legal, bit 2 fault clear (not stored), bits 3 and 4 enable holes 0 and 1. Hole i low bound is at select 3+2i, high bound at select 4+2i.
- R12: fault and fail_addr are registered; they reflect an access on the first clock edge at which the access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_is_io | input | 1 | 1 = programmed I/O, 0 = memory |
| acc_is_out | input | 1 | For I/O: 1 = output command, 0 = input command |
| acc_addr | input | 16 | Access address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| fault | output | 1 | Sticky illegal-access flag |
| fail_addr | output | 16 | Address of the first violating access |

## Verification
Every result of this block is due one clock edge after its stimulus: an access presented in a cycle shows on fault and fail_addr after the next rising edge, and a register write changes the judgement of accesses presented from the following cycle. The bench drives each access or write on a falling edge, lets exactly one rising edge pass, and samples the outputs at the following falling edge, so each check looks at the edge that carries its result. The same-cycle cases, a write together with an access and a clear together with a violation, are driven in a single cycle so that the ordering rules of R8 and R10 are tested on that one edge.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

  localparam int ADDR_W = 16;
  localparam int CMD_W  = 10;
  localparam int GRP_W  = ADDR_W - CMD_W;
  localparam int DATA_W = 16;

  // control register bit positions
  localparam int CTRL_IO_EN   = 0;
  localparam int CTRL_SPARE   = 1;
  localparam int CTRL_CLR     = 2;
  localparam int CTRL_HOLE0   = 3;

  // register selects; hole i uses SEL_HOLE_BASE+2i (low) and +1 (high)
  localparam int SEL_CTRL      = 0;
  localparam int SEL_LIM_OUT   = 1;
  localparam int SEL_LIM_IN    = 2;
  localparam int SEL_HOLE_BASE = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CMD_W-1:0]  cmd_t;
  typedef logic [GRP_W-1:0]  grp_t;

  typedef struct packed {
    logic  valid;
    logic  is_io;
    logic  is_out;
    addr_t addr;
  } acc_t;

  function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic cmd_t cmd_of(addr_t a);
    return a[CMD_W-1:0];
  endfunction

  function automatic grp_t grp_of(addr_t a);
    return a[ADDR_W-1:CMD_W];
  endfunction

  function automatic logic at_or_above(cmd_t c, cmd_t lim);
    return c >= lim;
  endfunction

  function automatic logic grp_between(grp_t g, grp_t lo, grp_t hi);
    return (g >= lo) && (g <= hi);
  endfunction

endpackage

// File: rtl/acc_guard_cfg.sv
module acc_guard_cfg
  import acc_guard_pkg::*;
#(
  parameter int NUM_HOLES = 2,
  parameter int SEL_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     io_en,
  output logic                     spare_ok,
  output logic                     clr_evt,
  output logic [NUM_HOLES-1:0]     hole_en,
  output addr_t [NUM_HOLES-1:0]    hole_lo,
  output addr_t [NUM_HOLES-1:0]    hole_hi,
  output cmd_t                     lim_out,
  output cmd_t                     lim_in
);

  logic ctrl_wr;
  assign ctrl_wr = we && (sel == SEL_W'(SEL_CTRL));
  assign clr_evt = ctrl_wr && wdata[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_en    <= 1'b0;
      spare_ok <= 1'b0;
      hole_en  <= '0;
    end else if (ctrl_wr) begin
      io_en    <= wdata[CTRL_IO_EN];
      spare_ok <= wdata[CTRL_SPARE];
      hole_en  <= wdata[CTRL_HOLE0 +: NUM_HOLES];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_out <= '1;
      lim_in  <= '1;
    end else if (we) begin
      if (sel == SEL_W'(SEL_LIM_OUT)) lim_out <= wdata[CMD_W-1:0];
      if (sel == SEL_W'(SEL_LIM_IN))  lim_in  <= wdata[CMD_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_HOLES; i++) begin : g_hole_regs
    localparam int SEL_LO = SEL_HOLE_BASE + 2 * i;
    localparam int SEL_HI = SEL_LO + 1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hole_lo[i] <= '0;
        hole_hi[i] <= '0;
      end else if (we) begin
        if (sel == SEL_W'(SEL_LO)) hole_lo[i] <= wdata[ADDR_W-1:0];
        if (sel == SEL_W'(SEL_HI)) hole_hi[i] <= wdata[ADDR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/acc_guard_rules.sv
module acc_guard_rules
  import acc_guard_pkg::*;
#(
  parameter int   NUM_HOLES = 2,
  parameter grp_t SPARE_LO  = 6'h30,
  parameter grp_t SPARE_HI  = 6'h3F
) (
  input  acc_t                     acc,
  input  logic                     io_en,
  input  logic                     spare_ok,
  input  logic [NUM_HOLES-1:0]     hole_en,
  input  addr_t [NUM_HOLES-1:0]    hole_lo,
  input  addr_t [NUM_HOLES-1:0]    hole_hi,
  input  cmd_t                     lim_out,
  input  cmd_t                     lim_in,
  output logic [NUM_HOLES-1:0]     hole_hit,
  output logic                     io_lim_hit,
  output logic                     spare_hit,
  output logic                     viol
);

  logic mem_acc;
  logic io_acc;
  cmd_t lim_sel;

  assign mem_acc = acc.valid && !acc.is_io;
  assign io_acc  = acc.valid &&  acc.is_io;
  assign lim_sel = acc.is_out ? lim_out : lim_in;

  for (genvar i = 0; i < NUM_HOLES; i++) begin : g_hole_cmp
    assign hole_hit[i] = mem_acc && hole_en[i] &&
                         in_window(acc.addr, hole_lo[i], hole_hi[i]);
  end

  assign io_lim_hit = io_acc && io_en && at_or_above(cmd_of(acc.addr), lim_sel);
  assign spare_hit  = io_acc && !spare_ok &&
                      grp_between(grp_of(acc.addr), SPARE_LO, SPARE_HI);

  assign viol = (|hole_hit) || io_lim_hit || spare_hit;

endmodule

// File: rtl/acc_guard_capture.sv
module acc_guard_capture
  import acc_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  viol,
  input  logic  clr_evt,
  input  addr_t addr,
  output logic  fault,
  output addr_t fail_addr
);

  logic armed;
  logic take;

  assign armed = !fault || clr_evt;
  assign take  = viol && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault     <= 1'b0;
      fail_addr <= '0;
    end else begin
      fault <= viol || (fault && !clr_evt);
      if (take) fail_addr <= addr;
    end
  end

endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_guard_pkg::*;
#(
  parameter int   NUM_HOLES = 2,
  parameter grp_t SPARE_LO  = 6'h30,
  parameter grp_t SPARE_HI  = 6'h3F,
  localparam int  SEL_W     = $clog2(SEL_HOLE_BASE + 2 * NUM_HOLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_io,
  input  logic              acc_is_out,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              fault,
  output logic [ADDR_W-1:0] fail_addr
);

  acc_t                  acc;
  logic                  io_en;
  logic                  spare_ok;
  logic                  clr_evt;
  logic [NUM_HOLES-1:0]  hole_en;
  addr_t [NUM_HOLES-1:0] hole_lo;
  addr_t [NUM_HOLES-1:0] hole_hi;
  cmd_t                  lim_out;
  cmd_t                  lim_in;
  logic [NUM_HOLES-1:0]  hole_hit;
  logic                  io_lim_hit;
  logic                  spare_hit;
  logic                  viol;

  assign acc = '{valid: acc_valid, is_io: acc_is_io, is_out: acc_is_out, addr: acc_addr};

  acc_guard_cfg #(
    .NUM_HOLES (NUM_HOLES),
    .SEL_W     (SEL_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .io_en    (io_en),
    .spare_ok (spare_ok),
    .clr_evt  (clr_evt),
    .hole_en  (hole_en),
    .hole_lo  (hole_lo),
    .hole_hi  (hole_hi),
    .lim_out  (lim_out),
    .lim_in   (lim_in)
  );

  acc_guard_rules #(
    .NUM_HOLES (NUM_HOLES),
    .SPARE_LO  (SPARE_LO),
    .SPARE_HI  (SPARE_HI)
  ) u_rules (
    .acc        (acc),
    .io_en      (io_en),
    .spare_ok   (spare_ok),
    .hole_en    (hole_en),
    .hole_lo    (hole_lo),
    .hole_hi    (hole_hi),
    .lim_out    (lim_out),
    .lim_in     (lim_in),
    .hole_hit   (hole_hit),
    .io_lim_hit (io_lim_hit),
    .spare_hit  (spare_hit),
    .viol       (viol)
  );

  acc_guard_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .viol      (viol),
    .clr_evt   (clr_evt),
    .addr      (acc_addr),
    .fault     (fault),
    .fail_addr (fail_addr)
  );

endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk
  import acc_guard_pkg::*;
#(
  parameter int NUM_HOLES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_is_io,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic                 fault,
  input logic [ADDR_W-1:0]    fail_addr,
  input logic                 viol,
  input logic                 clr_evt,
  input logic [NUM_HOLES-1:0] hole_hit,
  input logic                 io_lim_hit,
  input logic                 spare_hit
);

  assert_set_on_viol_R12: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> fault);

  assert_idle_keeps_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !acc_valid) |=> !fault);

  assert_hold_first_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr_evt) |=> $stable(fail_addr));

  assert_capture_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && (!fault || clr_evt)) |=> (fail_addr == $past(acc_addr)));

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !viol) |=> !fault);

  assert_mem_outside_holes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_is_io && (hole_hit == '0)) |-> !viol);

  assert_io_rules_only_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_is_io) |-> !(io_lim_hit || spare_hit));

endmodule

bind acc_guard acc_guard_chk #(.NUM_HOLES(NUM_HOLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_is_io  (acc_is_io),
  .acc_addr   (acc_addr),
  .fault      (fault),
  .fail_addr  (fail_addr),
  .viol       (viol),
  .clr_evt    (clr_evt),
  .hole_hit   (hole_hit),
  .io_lim_hit (io_lim_hit),
  .spare_hit  (spare_hit)
);

// File: tb/acc_guard_test.sv
module acc_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_is_io = 1'b0;
  logic        acc_is_out = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        fault;
  logic [15:0] fail_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] ctrl_sh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_guard uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_is_io  (acc_is_io),
    .acc_is_out (acc_is_out),
    .acc_addr   (acc_addr),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .fault      (fault),
    .fail_addr  (fail_addr)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // one cycle: optional write and optional access, both on the same edge
  task automatic cycle(input bit wr, input logic [2:0] sel, input logic [15:0] data,
                       input bit v, input bit io, input bit out, input logic [15:0] a);
    cfg_we     = wr;
    cfg_sel    = sel;
    cfg_wdata  = data;
    acc_valid  = v;
    acc_is_io  = io;
    acc_is_out = out;
    acc_addr   = a;
    @(negedge clk);
    cfg_we    = 1'b0;
    acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    if (sel == 3'd0) ctrl_sh = data & 16'hFFFB;
    cycle(1'b1, sel, data, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic acc(input bit io, input bit out, input logic [15:0] a);
    cycle(1'b0, 3'd0, 16'h0, 1'b1, io, out, a);
  endtask

  task automatic clear_fault();
    cycle(1'b1, 3'd0, ctrl_sh | 16'h0004, 1'b0, 1'b0, 1'b0, 16'h0);
    chk({15'd0, fault}, 16'd0, "R8 clear");
  endtask

  task automatic t_reset();
    chk({15'd0, fault}, 16'd0, "R1 fault after reset");
    chk(fail_addr, 16'h0000, "R1 fail_addr after reset");
    acc(1'b0, 1'b0, 16'h4000);
    chk({15'd0, fault}, 16'd0, "R1 holes off after reset");
    acc(1'b1, 1'b1, 16'h03FF);
    chk({15'd0, fault}, 16'd0, "R1 io check off after reset");
    acc(1'b1, 1'b0, 16'hC005);
    chk({15'd0, fault}, 16'd1, "R1 spare illegal after reset");
    chk(fail_addr, 16'hC005, "R1 spare address captured");
    clear_fault();
  endtask

  task automatic t_mem_holes();
    wr(3'd3, 16'h2000);
    wr(3'd4, 16'h2FFF);
    wr(3'd5, 16'h8000);
    wr(3'd6, 16'h80FF);
    wr(3'd0, 16'h0008);           // R11 hole 0 enable at bit 3
    acc(1'b0, 1'b0, 16'h1FFF);
    chk({15'd0, fault}, 16'd0, "R2 below low bound");
    acc(1'b0, 1'b0, 16'h3000);
    chk({15'd0, fault}, 16'd0, "R2 above high bound");
    acc(1'b0, 1'b0, 16'h2000);
    chk({15'd0, fault}, 16'd1, "R2 low bound hit");
    chk(fail_addr, 16'h2000, "R2 low bound address");
    clear_fault();
    acc(1'b0, 1'b0, 16'h2FFF);
    chk({15'd0, fault}, 16'd1, "R2 high bound hit");
    clear_fault();
    acc(1'b0, 1'b0, 16'h8010);
    chk({15'd0, fault}, 16'd0, "R3 disabled hole");
    acc(1'b1, 1'b0, 16'h2100);
    chk({15'd0, fault}, 16'd0, "R2 io access ignores memory hole");
    wr(3'd0, 16'h0018);           // R11 hole 1 enable at bit 4
    acc(1'b0, 1'b0, 16'h8010);
    chk({15'd0, fault}, 16'd1, "R11 hole 1 enabled");
    chk(fail_addr, 16'h8010, "R11 hole 1 address");
    clear_fault();
    wr(3'd5, 16'h9000);
    wr(3'd6, 16'h8000);
    acc(1'b0, 1'b0, 16'h8800);
    chk({15'd0, fault}, 16'd0, "R3 inverted bounds");
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_io_limits();
    wr(3'd1, 16'hFC40);           // upper bits ignored: output limit 0x040
    wr(3'd2, 16'h0100);
    wr(3'd0, 16'h0001);
    acc(1'b1, 1'b1, 16'h003F);
    chk({15'd0, fault}, 16'd0, "R4 output below limit");
    acc(1'b1, 1'b1, 16'h0040);
    chk({15'd0, fault}, 16'd1, "R4 output at limit (upper data bits ignored)");
    chk(fail_addr, 16'h0040, "R4 output address");
    clear_fault();
    acc(1'b1, 1'b0, 16'h0040);
    chk({15'd0, fault}, 16'd0, "R4 input uses its own limit");
    acc(1'b1, 1'b0, 16'h00FF);
    chk({15'd0, fault}, 16'd0, "R4 input below limit");
    acc(1'b1, 1'b0, 16'h0100);
    chk({15'd0, fault}, 16'd1, "R4 input at limit");
    clear_fault();
    acc(1'b1, 1'b1, 16'h0840);    // command 0x040 from low 10 bits
    chk({15'd0, fault}, 16'd1, "R4 command from low 10 bits");
    clear_fault();
    wr(3'd0, 16'h0000);
    acc(1'b1, 1'b1, 16'h0200);
    chk({15'd0, fault}, 16'd0, "R5 check disabled output");
    acc(1'b1, 1'b0, 16'h03FF);
    chk({15'd0, fault}, 16'd0, "R5 check disabled input");
  endtask

  task automatic t_spare();
    acc(1'b1, 1'b1, 16'hFFFF);
    chk({15'd0, fault}, 16'd1, "R6 spare top illegal");
    clear_fault();
    acc(1'b1, 1'b0, 16'hBFFF);
    chk({15'd0, fault}, 16'd0, "R6 below spare group");
    acc(1'b0, 1'b0, 16'hC000);
    chk({15'd0, fault}, 16'd0, "R6 memory unaffected by spare rule");
    wr(3'd0, 16'h0002);
    acc(1'b1, 1'b0, 16'hC000);
    chk({15'd0, fault}, 16'd0, "R6 spare legal when bit 1 set");
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_first_capture();
    wr(3'd3, 16'h2000);
    wr(3'd4, 16'h2FFF);
    wr(3'd0, 16'h0008);
    acc(1'b0, 1'b0, 16'h2100);
    acc(1'b0, 1'b0, 16'h2200);
    chk({15'd0, fault}, 16'd1, "R7 fault pending");
    chk(fail_addr, 16'h2100, "R7 first address kept");
    acc(1'b1, 1'b0, 16'hC001);
    chk(fail_addr, 16'h2100, "R7 kept after spare violation");
  endtask

  task automatic t_clear_race();
    cycle(1'b1, 3'd0, ctrl_sh | 16'h0004, 1'b1, 1'b0, 1'b0, 16'h2300);
    chk({15'd0, fault}, 16'd1, "R8 violation beats clear");
    chk(fail_addr, 16'h2300, "R8 re-armed capture");
    clear_fault();
    acc(1'b0, 1'b0, 16'h2400);
    chk(fail_addr, 16'h2400, "R8 capture after clear");
    clear_fault();
  endtask

  task automatic t_valid();
    cycle(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h2000);
    chk({15'd0, fault}, 16'd0, "R9 invalid access no fault");
    chk(fail_addr, 16'h2400, "R9 invalid access no capture");
  endtask

  task automatic t_cfg_timing();
    wr(3'd0, 16'h0000);
    cycle(1'b1, 3'd0, 16'h0008, 1'b1, 1'b0, 1'b0, 16'h2000);
    ctrl_sh = 16'h0008;
    chk({15'd0, fault}, 16'd0, "R10 same-cycle write uses old setting");
    acc(1'b0, 1'b0, 16'h2000);
    chk({15'd0, fault}, 16'd1, "R10 R12 new setting next cycle");
    clear_fault();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_holes();
    t_io_limits();
    t_spare();
    t_first_capture();
    t_clear_race();
    t_valid();
    t_cfg_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule